// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides whether a received CAN frame is kept or dropped. For each frame it takes the identifier (11-bit standard or 29-bit extended), the format and remote-request flags, the data length code and the first two data bytes. It compares them against four acceptance code bytes and four acceptance mask bytes. A mask bit of 1 marks the matching frame bit as don't-care. The decision is registered and appears one clock after a frame-valid strobe.

Three filter layouts are selectable. Single mode builds one long filter: for extended frames it covers the full identifier and RTR, and for standard frames it covers the identifier, RTR and both data bytes. Dual mode builds two shorter sub-filters, and a frame passes if either one matches. Only the first sub-filter also checks part of data byte 0 for standard frames. Legacy mode uses a separate code and mask byte pair that covers only the top eight bits of a standard identifier, and it rejects every extended frame.

Code, mask and mode inputs are treated as static configuration. They are only changed while the surrounding controller holds reception off.

Top module: `can_accept_filter`

## Requirements
- R1: `accept_valid` is high in exactly the cycle after a cycle in which `frame_valid` was high. `accept` is never high while `accept_valid` is low.
- R2: A mask bit of 1 removes the matching frame bit from the comparison. With every mask bit set, single mode accepts any frame.
- R3: In single mode, an extended frame is matched as the 32-bit string {ID28..ID0, RTR, 2 unused bits}. The string is split into bytes and compared MSB first: code byte 0 (`acc_code[7:0]`) holds ID28..21, and byte 3 (`acc_code[31:24]`) holds ID4..0 in bits 7..3 and RTR in bit 2. The mask bytes are laid out the same way in `acc_mask`.
- R4: In single mode, a standard frame is matched as {ID10..ID0, RTR} against code byte 0 followed by bits 7..4 of code byte 1.
- R5: In single mode, a standard frame is also matched on data byte 0 against code byte 2 (mask byte 2) and on data byte 1 against code byte 3 (mask byte 3). Each data check is skipped when RTR is set or when the DLC is too small to carry that byte.
- R6: In dual mode, a frame passes when either sub-filter matches. Sub-filter 1 uses code/mask bytes 0 and 1, and sub-filter 2 uses code/mask bytes 2 and 3.
- R7: In dual mode, an extended frame is compared only on ID28..13 per sub-filter, with the lower byte of the pair holding ID28..21. ID12..0 has no effect.
- R8: In dual mode, a standard frame is matched per sub-filter as {ID10..0, RTR} against the pair's upper 12 bits. Sub-filter 1 also matches data byte 0 against {code byte 1 low nibble, code byte 3 low nibble}, with its mask built the same way from mask bytes 1 and 3. This data check ignores DLC and RTR.
- R9: Legacy mode overrides dual mode. It accepts a standard frame when ID10..3 equals `legacy_code` at every bit where `legacy_mask` is 0, and it never accepts an extended frame.
- R10: While reset is asserted, and in the first cycle after it, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_valid | input | 1 | Strobe: frame fields are valid this cycle |
| frame_ide | input | 1 | 1 = extended (29-bit) identifier |
| frame_rtr | input | 1 | Remote transmission request flag |
| frame_id | input | 29 | Identifier; standard frames use bits 10..0 |
| frame_dlc | input | 4 | Data length code |
| frame_data0 | input | 8 | First data byte |
| frame_data1 | input | 8 | Second data byte |
| legacy_mode | input | 1 | Select one-byte legacy filter |
| dual_mode | input | 1 | 1 = two sub-filters, 0 = one long filter |
| acc_code | input | 32 | Acceptance code bytes, byte k at bits 8k+7..8k |
| acc_mask | input | 32 | Acceptance mask bytes, same packing, 1 = don't care |
| legacy_code | input | 8 | Legacy code byte for ID10..3 |
| legacy_mask | input | 8 | Legacy mask byte, 1 = don't care |
| accept_valid | output | 1 | Decision is valid this cycle |
| accept | output | 1 | Frame accepted |

## Verification
Each mode is run with a frame built to match exactly, and then with the same frame with a single identifier bit or RTR bit flipped. This shows that each bit position sits where the layout says it does. A flipped bit that is then masked must flip the decision back, which separates mask polarity from code position. In single standard mode, wrong data bytes are paired with DLC values of 0, 1 and 2 and with RTR frames, which confirms each skip condition on its own. Dual mode frames hit only one sub-filter, both, or neither. Among these, wrong low-ID bits in extended frames and a wrong data nibble at DLC 0 show which fields each sub-filter ignores.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

    localparam int BYTE_W  = 8;
    localparam int N_BYTES = 4;
    localparam int CFG_W   = BYTE_W * N_BYTES;
    localparam int EXT_W   = 29;
    localparam int STD_W   = 11;
    localparam int DLC_W   = 4;
    localparam int N_SUB   = 2;
    localparam int SUB_W   = 2 * BYTE_W;

    typedef struct packed {
        logic               ide;
        logic               rtr;
        logic [EXT_W-1:0]   id;
        logic [DLC_W-1:0]   dlc;
        logic [BYTE_W-1:0]  d0;
        logic [BYTE_W-1:0]  d1;
    } rx_frame_t;

    typedef struct packed {
        logic vld;
        logic acc;
    } dec_state_t;

    // 1 when every bit not masked off agrees
    function automatic logic masked_eq(input logic [CFG_W-1:0] f,
                                       input logic [CFG_W-1:0] c,
                                       input logic [CFG_W-1:0] m);
        return (((f ^ c) & ~m) == '0);
    endfunction

endpackage

// File: rtl/can_filt_single.sv
module can_filt_single
    import can_filt_pkg::*;
(
    input  rx_frame_t          frm,
    input  logic [CFG_W-1:0]   code_str,
    input  logic [CFG_W-1:0]   mask_str,
    output logic               hit
);
    logic [CFG_W-1:0] ext_vec;
    logic [SUB_W-1:0] std_vec;
    logic             id_ok_ext;
    logic             id_ok_std;
    logic             d0_ok;
    logic             d1_ok;

    always_comb begin
        ext_vec   = {frm.id, frm.rtr, 2'b00};
        std_vec   = {frm.id[STD_W-1:0], frm.rtr, 4'b0000};
        id_ok_ext = masked_eq(ext_vec,
                              code_str,
                              mask_str | CFG_W'(2'b11));
        id_ok_std = masked_eq({std_vec, 16'h0},
                              {code_str[CFG_W-1 -: SUB_W], 16'h0},
                              {mask_str[CFG_W-1 -: SUB_W] | 16'h000F, 16'hFFFF});
        d0_ok = frm.rtr || (frm.dlc == '0) ||
                masked_eq({frm.d0, 24'h0}, {code_str[15:8], 24'h0},
                          {mask_str[15:8], 24'hFFFFFF});
        d1_ok = frm.rtr || (frm.dlc < DLC_W'(2)) ||
                masked_eq({frm.d1, 24'h0}, {code_str[7:0], 24'h0},
                          {mask_str[7:0], 24'hFFFFFF});
        hit = frm.ide ? id_ok_ext : (id_ok_std && d0_ok && d1_ok);
    end
endmodule

// File: rtl/can_filt_dual_sub.sv
module can_filt_dual_sub
    import can_filt_pkg::*;
#(
    parameter bit WITH_DATA = 1'b0
) (
    input  logic               ide,
    input  logic               rtr,
    input  logic [15:0]        id_hi,
    input  logic [STD_W-1:0]   id_std,
    input  logic [BYTE_W-1:0]  d0,
    input  logic [SUB_W-1:0]   code_pair,
    input  logic [SUB_W-1:0]   mask_pair,
    input  logic [BYTE_W-1:0]  d_code,
    input  logic [BYTE_W-1:0]  d_mask,
    output logic               hit
);
    logic ext_ok;
    logic std_ok;
    logic dat_ok;

    always_comb begin
        ext_ok = masked_eq({id_hi, 16'h0}, {code_pair, 16'h0},
                           {mask_pair, 16'hFFFF});
        std_ok = masked_eq({id_std, rtr, 20'h0}, {code_pair, 16'h0},
                           {mask_pair | 16'h000F, 16'hFFFF});
        dat_ok = masked_eq({d0, 24'h0}, {d_code, 24'h0},
                           {d_mask, 24'hFFFFFF}) || !WITH_DATA;
        hit = ide ? ext_ok : (std_ok && dat_ok);
    end
endmodule

// File: rtl/can_filt_legacy.sv
module can_filt_legacy
    import can_filt_pkg::*;
(
    input  logic               ide,
    input  logic [BYTE_W-1:0]  id_top,
    input  logic [BYTE_W-1:0]  code_b,
    input  logic [BYTE_W-1:0]  mask_b,
    output logic               hit
);
    always_comb begin
        hit = !ide && (((id_top ^ code_b) & ~mask_b) == '0);
    end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import can_filt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_valid,
    input  logic               frame_ide,
    input  logic               frame_rtr,
    input  logic [28:0]        frame_id,
    input  logic [3:0]         frame_dlc,
    input  logic [7:0]         frame_data0,
    input  logic [7:0]         frame_data1,
    input  logic               legacy_mode,
    input  logic               dual_mode,
    input  logic [31:0]        acc_code,
    input  logic [31:0]        acc_mask,
    input  logic [7:0]         legacy_code,
    input  logic [7:0]         legacy_mask,
    output logic               accept_valid,
    output logic               accept
);
    rx_frame_t         frm;
    logic [CFG_W-1:0]  code_str;
    logic [CFG_W-1:0]  mask_str;
    logic              single_hit;
    logic              legacy_hit;
    logic [N_SUB-1:0]  sub_hit;
    logic              decide;
    dec_state_t        st_d;
    dec_state_t        st_q;

    always_comb begin
        frm = '{ide: frame_ide, rtr: frame_rtr, id: frame_id,
                dlc: frame_dlc, d0: frame_data0, d1: frame_data1};
    end

    // byte 0 is the most significant byte of the match string
    for (genvar k = 0; k < N_BYTES; k++) begin : g_str
        assign code_str[CFG_W-1-BYTE_W*k -: BYTE_W] = acc_code[BYTE_W*k +: BYTE_W];
        assign mask_str[CFG_W-1-BYTE_W*k -: BYTE_W] = acc_mask[BYTE_W*k +: BYTE_W];
    end

    can_filt_single u_single (
        .frm      (frm),
        .code_str (code_str),
        .mask_str (mask_str),
        .hit      (single_hit)
    );

    for (genvar s = 0; s < N_SUB; s++) begin : g_sub
        can_filt_dual_sub #(.WITH_DATA(s == 0)) u_sub (
            .ide       (frame_ide),
            .rtr       (frame_rtr),
            .id_hi     (frame_id[EXT_W-1 -: 16]),
            .id_std    (frame_id[STD_W-1:0]),
            .d0        (frame_data0),
            .code_pair (code_str[CFG_W-1-SUB_W*s -: SUB_W]),
            .mask_pair (mask_str[CFG_W-1-SUB_W*s -: SUB_W]),
            .d_code    ({acc_code[11:8], acc_code[27:24]}),
            .d_mask    ({acc_mask[11:8], acc_mask[27:24]}),
            .hit       (sub_hit[s])
        );
    end

    can_filt_legacy u_legacy (
        .ide    (frame_ide),
        .id_top (frame_id[STD_W-1 -: BYTE_W]),
        .code_b (legacy_code),
        .mask_b (legacy_mask),
        .hit    (legacy_hit)
    );

    always_comb begin
        if (legacy_mode)    decide = legacy_hit;
        else if (dual_mode) decide = |sub_hit;
        else                decide = single_hit;
        st_d.vld = frame_valid;
        st_d.acc = frame_valid && decide;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign accept_valid = st_q.vld;
    assign accept       = st_q.acc;
endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_valid,
    input logic        frame_ide,
    input logic        legacy_mode,
    input logic        dual_mode,
    input logic [31:0] acc_mask,
    input logic        accept_valid,
    input logic        accept
);
    assert_valid_lag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> accept_valid);
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> !accept_valid);
    assert_acc_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> accept_valid);
    assert_open_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !legacy_mode && !dual_mode && (&acc_mask)) |=> accept);
    assert_open_sub2_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !legacy_mode && dual_mode && (&acc_mask[31:16])) |=> accept);
    assert_legacy_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && legacy_mode && frame_ide) |=> !accept);
endmodule

bind can_accept_filter can_accept_filter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_valid  (frame_valid),
    .frame_ide    (frame_ide),
    .legacy_mode  (legacy_mode),
    .dual_mode    (dual_mode),
    .acc_mask     (acc_mask),
    .accept_valid (accept_valid),
    .accept       (accept)
);

// File: tb/can_accept_filter_tb.sv
`timescale 1ns/1ps
module can_accept_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_valid = 1'b0;
    logic        frame_ide = 1'b0;
    logic        frame_rtr = 1'b0;
    logic [28:0] frame_id = '0;
    logic [3:0]  frame_dlc = '0;
    logic [7:0]  frame_data0 = '0;
    logic [7:0]  frame_data1 = '0;
    logic        legacy_mode = 1'b0;
    logic        dual_mode = 1'b0;
    logic [31:0] acc_code = '0;
    logic [31:0] acc_mask = '0;
    logic [7:0]  legacy_code = '0;
    logic [7:0]  legacy_mask = '0;
    logic        accept_valid;
    logic        accept;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    can_accept_filter u_dut (.*);

    function automatic logic [31:0] pack4(input logic [7:0] b0, b1, b2, b3);
        return {b3, b2, b1, b0};
    endfunction

    task automatic check(input string req, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    // drive at negedge, register at posedge, sample at the following negedge
    task automatic run(input string req, input logic ide, input logic rtr,
                       input logic [28:0] id, input logic [3:0] dlc,
                       input logic [7:0] d0, input logic [7:0] d1,
                       input logic exp);
        @(negedge clk);
        frame_valid = 1'b1; frame_ide = ide; frame_rtr = rtr; frame_id = id;
        frame_dlc = dlc; frame_data0 = d0; frame_data1 = d1;
        @(negedge clk);
        frame_valid = 1'b0;
        check({req, " valid"}, accept_valid, 1'b1);
        check(req, accept, exp);
    endtask

    task automatic t_reset;
        check("R10 reset valid", accept_valid, 1'b0);
        check("R10 reset accept", accept, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R10 post-reset valid", accept_valid, 1'b0);
        check("R10 post-reset accept", accept, 1'b0);
    endtask

    task automatic t_single_ext;
        logic [28:0] id = 29'h0ABCDEF1;
        logic [31:0] cv = {id, 1'b0, 2'b00};
        legacy_mode = 0; dual_mode = 0;
        acc_code = pack4(cv[31:24], cv[23:16], cv[15:8], cv[7:0]);
        acc_mask = '0;
        run("R3 ext exact", 1, 0, id, 4'd8, 8'h00, 8'h00, 1);
        run("R3 ext id0 flip", 1, 0, id ^ 29'h1, 4'd8, 8'h00, 8'h00, 0);
        run("R3 ext id28 flip", 1, 0, id ^ 29'h10000000, 4'd8, 8'h00, 8'h00, 0);
        run("R3 ext rtr flip", 1, 1, id, 4'd0, 8'h00, 8'h00, 0);
        acc_mask = pack4(8'h00, 8'h00, 8'h00, 8'h08);
        run("R2 ext id0 masked", 1, 0, id ^ 29'h1, 4'd8, 8'h00, 8'h00, 1);
        acc_mask = '1;
        run("R2 all masked", 1, 1, 29'h1FFFFFFF, 4'd3, 8'h12, 8'h34, 1);
    endtask

    task automatic t_single_std;
        logic [15:0] cv = {11'h5A3, 1'b0, 4'h0};
        legacy_mode = 0; dual_mode = 0;
        acc_code = pack4(cv[15:8], cv[7:0], 8'h3C, 8'hC3);
        acc_mask = '0;
        run("R4 std exact", 0, 0, 29'h5A3, 4'd2, 8'h3C, 8'hC3, 1);
        run("R4 std id flip", 0, 0, 29'h5A2, 4'd2, 8'h3C, 8'hC3, 0);
        run("R5 d1 wrong dlc2", 0, 0, 29'h5A3, 4'd2, 8'h3C, 8'h00, 0);
        run("R5 d1 wrong dlc1", 0, 0, 29'h5A3, 4'd1, 8'h3C, 8'h00, 1);
        run("R5 d0 wrong dlc1", 0, 0, 29'h5A3, 4'd1, 8'h3D, 8'hC3, 0);
        run("R5 d0 wrong dlc0", 0, 0, 29'h5A3, 4'd0, 8'h00, 8'h00, 1);
        acc_mask = pack4(8'h00, 8'h10, 8'h00, 8'h00);
        run("R5 rtr skips data", 0, 1, 29'h5A3, 4'd8, 8'h00, 8'h00, 1);
        acc_mask = pack4(8'h00, 8'h00, 8'hFF, 8'h00);
        run("R2 d0 masked", 0, 0, 29'h5A3, 4'd2, 8'h99, 8'hC3, 1);
    endtask

    task automatic t_dual_ext;
        logic [28:0] ida = 29'h1234_5678 & 29'h1FFFFFFF;
        logic [28:0] idb = 29'h0F0F_0F0F;
        legacy_mode = 0; dual_mode = 1;
        acc_code = pack4(ida[28:21], ida[20:13], idb[28:21], idb[20:13]);
        acc_mask = '0;
        run("R7 ext sub1", 1, 0, ida, 4'd1, 8'h00, 8'h00, 1);
        run("R7 ext sub1 low ignored", 1, 1, ida ^ 29'h1FFF, 4'd0, 8'h00, 8'h00, 1);
        run("R6 ext sub2", 1, 0, idb, 4'd1, 8'h00, 8'h00, 1);
        run("R6 ext neither", 1, 0, ida ^ 29'h2000, 4'd1, 8'h00, 8'h00, 0);
        acc_mask = pack4(8'h00, 8'h00, 8'hFF, 8'hFF);
        run("R6 ext sub2 open", 1, 0, 29'h0000_0001, 4'd1, 8'h00, 8'h00, 1);
    endtask

    task automatic t_dual_std;
        legacy_mode = 0; dual_mode = 1;
        acc_code = pack4(8'h24, 8'h69, 8'hFE, 8'h0E);
        acc_mask = '0;
        run("R8 std sub1 data ok", 0, 0, 29'h123, 4'd1, 8'h9E, 8'h00, 1);
        run("R8 std sub1 data bad", 0, 0, 29'h123, 4'd1, 8'h9F, 8'h00, 0);
        run("R8 data checked dlc0", 0, 0, 29'h123, 4'd0, 8'h9F, 8'h00, 0);
        run("R8 std sub2 no data", 0, 0, 29'h7F0, 4'd1, 8'h00, 8'h00, 1);
        run("R8 std sub2 rtr flip", 0, 1, 29'h7F0, 4'd1, 8'h00, 8'h00, 0);
        acc_mask = pack4(8'h00, 8'h0F, 8'h00, 8'h0F);
        run("R8 std data masked", 0, 0, 29'h123, 4'd1, 8'h00, 8'h00, 1);
    endtask

    task automatic t_legacy;
        legacy_mode = 1; dual_mode = 1;
        acc_code = '0; acc_mask = '0;
        legacy_code = 8'hA5; legacy_mask = 8'h0F;
        run("R9 legacy exact", 0, 0, {18'h0, 8'hA5, 3'b111}, 4'd0, 8'h00, 8'h00, 1);
        run("R9 legacy low masked", 0, 1, {18'h0, 8'hAA, 3'b000}, 4'd0, 8'h00, 8'h00, 1);
        run("R9 legacy reject", 0, 0, {18'h0, 8'h55, 3'b000}, 4'd0, 8'h00, 8'h00, 0);
        run("R9 legacy extended", 1, 0, {18'h0, 8'hA5, 3'b000}, 4'd0, 8'h00, 8'h00, 0);
    endtask

    task automatic t_strobe;
        legacy_mode = 0; dual_mode = 0; acc_mask = '1;
        @(negedge clk);
        frame_valid = 1'b0;
        @(negedge clk);
        check("R1 no strobe valid", accept_valid, 1'b0);
        check("R1 no strobe accept", accept, 1'b0);
    endtask

    initial begin
        t_reset();
        t_single_ext();
        t_single_std();
        t_dual_ext();
        t_dual_std();
        t_legacy();
        t_strobe();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule